// File: doc/BRIEF.md
# Display Window and Scan Address Generator

This block sits behind the panel's clock input. For a 960 x 234 RGB-stripe panel it turns an external dot or pixel clock and two active-low sync inputs into a data-valid strobe, a column address and a line address. The design runs entirely on the external clock. Horizontal sync passes through a synchronizer and is edge-detected to mark the start of each line. Vertical sync is captured only when horizontal sync rises, and a high-to-low change in that capture restarts the frame.

Two sampling modes set the horizontal window. Independent mode issues one position per colour dot, and simultaneous mode issues one position per RGB pixel. Each axis can be mirrored on its own, so a rotated mounting can be handled without touching the pixel source. Every line length is measured against a legal band for the active mode, and any violation is kept in a sticky flag until it is cleared. A new sampling mode takes effect only at the next frame start, so no frame is decoded with two different windows.

Top module: `scan_window_gen`

## Requirements
- R1: While reset is high and after it is released, data_valid, col_addr, line_addr and line_len_err are 0, and independent mode is the active sampling mode.
- R2: Call edge 0 the first rising clock edge at which hsync_n is low after being high. Line position 0 is in effect after edge 2, and the position then rises by one at each edge. vsync_n is sampled when the synchronized horizontal sync rises, which takes effect two edges after the first edge that sees hsync_n high. A sampled change of vsync_n from 1 to 0 sets the line index to 0. The line index then rises by one at each later line start.
- R3: In independent mode the horizontal window covers positions 205 to 1164, and the column offset runs from 0 to 959.
- R4: In simultaneous mode the horizontal window covers positions 84 to 403, and the column offset runs from 0 to 319.
- R5: The vertical window covers line indices 20 to 253, and the line offset runs from 0 to 233. Line 254 is blank.
- R6: With hdir_asc high, col_addr equals the column offset. With hdir_asc low, col_addr equals (window width - 1 - offset), so it descends along the line.
- R7: With vdir_asc high, line_addr equals the line offset. With vdir_asc low, line_addr equals 233 - offset.
- R8: data_valid is 1 only when both windows hold. Whenever data_valid is 0, col_addr and line_addr are 0.
- R9: A line's length is the number of clocks between its start and the next line start. At each line start after the first one following reset, the length of the line that just ended is checked against the active mode: 1170 to 1230 in independent mode, 405 to 465 in simultaneous mode. A length outside that band sets line_len_err, visible after that start edge. The flag then stays set.
- R10: When err_clr is high at a rising edge, line_len_err is 0 after that edge. This clear wins over a violation detected at the same edge.
- R11: samp_ind (1 = independent, 0 = simultaneous) is copied into the active mode only at a frame start. Lines decoded before that frame start keep the previous window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | External dot or pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| hsync_n | input | 1 | Horizontal sync, active low |
| vsync_n | input | 1 | Vertical sync, active low |
| samp_ind | input | 1 | Requested sampling mode: 1 independent, 0 simultaneous |
| hdir_asc | input | 1 | 1 = ascending columns, 0 = mirrored |
| vdir_asc | input | 1 | 1 = ascending lines, 0 = mirrored |
| err_clr | input | 1 | Synchronous clear of the line-length flag |
| data_valid | output | 1 | Current clock lies inside the visible window |
| col_addr | output | 10 | Column address, 0 outside the window |
| line_addr | output | 8 | Line address, 0 outside the window |
| line_len_err | output | 1 | Sticky line-length violation flag |

## Verification
The bench drives whole lines and frames and compares every cycle against its own window model. It pins down the first and last visible position and address of a line in both modes. A decoder with an off-by-one in the synchronizer latency, or in either window bound, would show a shifted or shortened run of valid cycles. The bench tests line lengths one clock inside and one clock outside each legal band, and it fires a clear in the same cycle as a violation. A comparator with the wrong inclusive bounds, or a set that overrides the clear, would leave the flag in the wrong state. The bench also changes the mode request in the middle of a frame and checks that the old window persists until the next frame start. It runs a full simultaneous frame to reach the last visible line and the blank line after it, and it repeats the run with both axes mirrored. A decoder that mixed windows, leaked past line 253 or mirrored with the wrong width would be caught by these runs.

// File: rtl/scan_pkg.sv
package scan_pkg;

    // Default geometry and timing of the scan window
    localparam int IND_H_START = 205;
    localparam int IND_H_SPAN  = 960;
    localparam int SIM_H_START = 84;
    localparam int SIM_H_SPAN  = 320;
    localparam int V_START_DEF = 20;
    localparam int V_SPAN_DEF  = 234;
    localparam int IND_LEN_LO  = 1170;
    localparam int IND_LEN_HI  = 1230;
    localparam int SIM_LEN_LO  = 405;
    localparam int SIM_LEN_HI  = 465;
    localparam int HCNT_W_DEF  = 11;
    localparam int VCNT_W_DEF  = 9;

    typedef enum logic {
        SAMP_SIM = 1'b0,
        SAMP_IND = 1'b1
    } samp_mode_e;

    typedef struct packed {
        logic fall;
        logic rise;
    } sync_edge_t;

    function automatic logic span_hit(input int unsigned v,
                                      input int unsigned lo,
                                      input int unsigned n);
        return (v >= lo) && (v < lo + n);
    endfunction

    function automatic logic band_hit(input int unsigned v,
                                      input int unsigned lo,
                                      input int unsigned hi);
        return (v >= lo) && (v <= hi);
    endfunction

    function automatic int unsigned mirror(input int unsigned off,
                                           input int unsigned n,
                                           input logic        asc);
        return asc ? off : (n - 1 - off);
    endfunction

endpackage

// File: rtl/scan_sync.sv
module scan_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= 1'b1;
        else     chain[0] <= din;
    end

    generate
        for (genvar i = 1; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) chain[i] <= 1'b1;
                else     chain[i] <= chain[i-1];
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/scan_line_timer.sv
module scan_line_timer
    import scan_pkg::*;
#(
    parameter int HCNT_W  = HCNT_W_DEF,
    parameter int IND_LO  = IND_LEN_LO,
    parameter int IND_HI  = IND_LEN_HI,
    parameter int SIM_LO  = SIM_LEN_LO,
    parameter int SIM_HI  = SIM_LEN_HI
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hs_lvl,
    input  samp_mode_e        mode,
    input  logic              err_clr,
    output logic [HCNT_W-1:0] hcnt,
    output sync_edge_t        hs_ev,
    output logic              len_err
);
    logic hs_prev;
    logic seen;
    logic len_ok;

    assign hs_ev.fall = hs_prev & ~hs_lvl;
    assign hs_ev.rise = ~hs_prev & hs_lvl;

    always_comb begin
        if (mode == SAMP_IND)
            len_ok = band_hit(32'(hcnt) + 32'd1, IND_LO, IND_HI);
        else
            len_ok = band_hit(32'(hcnt) + 32'd1, SIM_LO, SIM_HI);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hs_prev <= 1'b1;
            hcnt    <= '0;
            seen    <= 1'b0;
            len_err <= 1'b0;
        end else begin
            hs_prev <= hs_lvl;
            if (hs_ev.fall)
                hcnt <= '0;
            else if (hcnt != '1)
                hcnt <= hcnt + 1'b1;
            if (hs_ev.fall)
                seen <= 1'b1;
            if (err_clr)
                len_err <= 1'b0;
            else if (hs_ev.fall && seen && !len_ok)
                len_err <= 1'b1;
        end
    end
endmodule

// File: rtl/scan_frame_timer.sv
module scan_frame_timer
    import scan_pkg::*;
#(
    parameter int VCNT_W = VCNT_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              vs_lvl,
    input  sync_edge_t        hs_ev,
    input  samp_mode_e        mode_req,
    output logic [VCNT_W-1:0] vcnt,
    output samp_mode_e        mode_q,
    output logic              v_evt
);
    logic vs_smp;

    assign v_evt = hs_ev.rise & vs_smp & ~vs_lvl;

    always_ff @(posedge clk) begin
        if (rst) begin
            vs_smp <= 1'b1;
            vcnt   <= '0;
            mode_q <= SAMP_IND;
        end else begin
            if (hs_ev.rise)
                vs_smp <= vs_lvl;
            if (v_evt) begin
                vcnt   <= '0;
                mode_q <= mode_req;
            end else if (hs_ev.fall && vcnt != '1) begin
                vcnt <= vcnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/scan_window_decode.sv
module scan_window_decode
    import scan_pkg::*;
#(
    parameter int HCNT_W   = HCNT_W_DEF,
    parameter int VCNT_W   = VCNT_W_DEF,
    parameter int COL_W    = 10,
    parameter int LINE_W   = 8,
    parameter int IND_ST   = IND_H_START,
    parameter int IND_SP   = IND_H_SPAN,
    parameter int SIM_ST   = SIM_H_START,
    parameter int SIM_SP   = SIM_H_SPAN,
    parameter int V_ST     = V_START_DEF,
    parameter int V_SP     = V_SPAN_DEF
) (
    input  logic [HCNT_W-1:0] hcnt,
    input  logic [VCNT_W-1:0] vcnt,
    input  samp_mode_e        mode,
    input  logic              hdir_asc,
    input  logic              vdir_asc,
    output logic              valid,
    output logic [COL_W-1:0]  col,
    output logic [LINE_W-1:0] line
);
    int unsigned h_start;
    int unsigned h_span;
    logic        h_hit;
    logic        v_hit;

    always_comb begin
        h_start = (mode == SAMP_IND) ? IND_ST : SIM_ST;
        h_span  = (mode == SAMP_IND) ? IND_SP : SIM_SP;
        h_hit   = span_hit(32'(hcnt), h_start, h_span);
        v_hit   = span_hit(32'(vcnt), V_ST, V_SP);
        valid   = h_hit && v_hit;
        col     = '0;
        line    = '0;
        if (valid) begin
            col  = COL_W'(mirror(32'(hcnt) - h_start, h_span, hdir_asc));
            line = LINE_W'(mirror(32'(vcnt) - V_ST, V_SP, vdir_asc));
        end
    end
endmodule

// File: rtl/scan_window_gen.sv
module scan_window_gen
    import scan_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int HCNT_W      = HCNT_W_DEF,
    parameter int VCNT_W      = VCNT_W_DEF,
    parameter int H_IND_START = IND_H_START,
    parameter int H_IND_DOTS  = IND_H_SPAN,
    parameter int H_SIM_START = SIM_H_START,
    parameter int H_SIM_PIX   = SIM_H_SPAN,
    parameter int V_START     = V_START_DEF,
    parameter int V_LINES     = V_SPAN_DEF,
    parameter int LEN_IND_LO  = IND_LEN_LO,
    parameter int LEN_IND_HI  = IND_LEN_HI,
    parameter int LEN_SIM_LO  = SIM_LEN_LO,
    parameter int LEN_SIM_HI  = SIM_LEN_HI,
    localparam int COL_W      = $clog2(H_IND_DOTS),
    localparam int LINE_W     = $clog2(V_LINES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hsync_n,
    input  logic              vsync_n,
    input  logic              samp_ind,
    input  logic              hdir_asc,
    input  logic              vdir_asc,
    input  logic              err_clr,
    output logic              data_valid,
    output logic [COL_W-1:0]  col_addr,
    output logic [LINE_W-1:0] line_addr,
    output logic              line_len_err
);
    logic              hs_lvl;
    logic              vs_lvl;
    logic [HCNT_W-1:0] hcnt;
    logic [VCNT_W-1:0] vcnt;
    sync_edge_t        hs_ev;
    samp_mode_e        mode_q;
    logic              v_evt;

    scan_sync #(.STAGES(SYNC_STAGES)) u_hs_sync (
        .clk(clk), .rst(rst), .din(hsync_n), .dout(hs_lvl)
    );

    scan_sync #(.STAGES(SYNC_STAGES)) u_vs_sync (
        .clk(clk), .rst(rst), .din(vsync_n), .dout(vs_lvl)
    );

    scan_line_timer #(
        .HCNT_W(HCNT_W),
        .IND_LO(LEN_IND_LO), .IND_HI(LEN_IND_HI),
        .SIM_LO(LEN_SIM_LO), .SIM_HI(LEN_SIM_HI)
    ) u_line (
        .clk(clk), .rst(rst), .hs_lvl(hs_lvl), .mode(mode_q),
        .err_clr(err_clr), .hcnt(hcnt), .hs_ev(hs_ev), .len_err(line_len_err)
    );

    scan_frame_timer #(.VCNT_W(VCNT_W)) u_frame (
        .clk(clk), .rst(rst), .vs_lvl(vs_lvl), .hs_ev(hs_ev),
        .mode_req(samp_mode_e'(samp_ind)), .vcnt(vcnt),
        .mode_q(mode_q), .v_evt(v_evt)
    );

    scan_window_decode #(
        .HCNT_W(HCNT_W), .VCNT_W(VCNT_W), .COL_W(COL_W), .LINE_W(LINE_W),
        .IND_ST(H_IND_START), .IND_SP(H_IND_DOTS),
        .SIM_ST(H_SIM_START), .SIM_SP(H_SIM_PIX),
        .V_ST(V_START), .V_SP(V_LINES)
    ) u_dec (
        .hcnt(hcnt), .vcnt(vcnt), .mode(mode_q),
        .hdir_asc(hdir_asc), .vdir_asc(vdir_asc),
        .valid(data_valid), .col(col_addr), .line(line_addr)
    );
endmodule

// File: rtl/scan_window_gen_chk.sv
module scan_window_gen_chk
    import scan_pkg::*;
#(
    parameter int COL_W      = 10,
    parameter int LINE_W     = 8,
    parameter int H_IND_DOTS = IND_H_SPAN,
    parameter int H_SIM_PIX  = SIM_H_SPAN,
    parameter int V_LINES    = V_SPAN_DEF
) (
    input logic              clk,
    input logic              rst,
    input logic              hdir_asc,
    input logic              err_clr,
    input logic              data_valid,
    input logic [COL_W-1:0]  col_addr,
    input logic [LINE_W-1:0] line_addr,
    input logic              line_len_err,
    input samp_mode_e        mode_q,
    input logic              v_evt
);
    assert_idle_zero_R8: assert property (@(posedge clk) disable iff (rst)
        !data_valid |-> (col_addr == '0 && line_addr == '0));

    assert_col_ind_range_R3: assert property (@(posedge clk) disable iff (rst)
        (data_valid && mode_q == SAMP_IND) |-> (32'(col_addr) < H_IND_DOTS));

    assert_col_sim_range_R4: assert property (@(posedge clk) disable iff (rst)
        (data_valid && mode_q == SAMP_SIM) |-> (32'(col_addr) < H_SIM_PIX));

    assert_line_range_R5: assert property (@(posedge clk) disable iff (rst)
        data_valid |-> (32'(line_addr) < V_LINES));

    assert_col_up_R6: assert property (@(posedge clk) disable iff (rst)
        (data_valid && $past(data_valid) && hdir_asc && $past(hdir_asc) && $stable(mode_q))
        |-> (col_addr == COL_W'($past(col_addr) + 1'b1)));

    assert_col_down_R6: assert property (@(posedge clk) disable iff (rst)
        (data_valid && $past(data_valid) && !hdir_asc && !$past(hdir_asc) && $stable(mode_q))
        |-> (col_addr == COL_W'($past(col_addr) - 1'b1)));

    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        (line_len_err && !err_clr) |=> line_len_err);

    assert_err_clear_R10: assert property (@(posedge clk) disable iff (rst)
        err_clr |=> !line_len_err);

    assert_mode_at_frame_R11: assert property (@(posedge clk) disable iff (rst)
        !$stable(mode_q) |-> $past(v_evt));
endmodule

bind scan_window_gen scan_window_gen_chk #(
    .COL_W(COL_W), .LINE_W(LINE_W),
    .H_IND_DOTS(H_IND_DOTS), .H_SIM_PIX(H_SIM_PIX), .V_LINES(V_LINES)
) u_chk (
    .clk(clk), .rst(rst), .hdir_asc(hdir_asc), .err_clr(err_clr),
    .data_valid(data_valid), .col_addr(col_addr), .line_addr(line_addr),
    .line_len_err(line_len_err), .mode_q(mode_q), .v_evt(v_evt)
);

// File: tb/scan_window_gen_tb.sv
module scan_window_gen_tb;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst;
    logic       hsync_n, vsync_n, samp_ind, hdir_asc, vdir_asc, err_clr;
    logic       data_valid;
    logic [9:0] col_addr;
    logic [7:0] line_addr;
    logic       line_len_err;

    scan_window_gen u_dut (
        .clk(clk), .rst(rst), .hsync_n(hsync_n), .vsync_n(vsync_n),
        .samp_ind(samp_ind), .hdir_asc(hdir_asc), .vdir_asc(vdir_asc),
        .err_clr(err_clr), .data_valid(data_valid), .col_addr(col_addr),
        .line_addr(line_addr), .line_len_err(line_len_err)
    );

    int checks = 0;
    int errors = 0;

    // Bench model state, derived from the requirements
    int  m_pos = 0, m_line = 0, m_mode = 1, m_vs_prev = 1, m_err = 0;
    int  last_len = 0, seen = 0;
    int  nvalid, first_col, last_col, last_line;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic bit len_legal(input int len, input int mode);
        if (mode == 1) return (len >= 1170 && len <= 1230);
        return (len >= 405 && len <= 465);
    endfunction

    // Drives one line starting at a negedge; compares every cycle
    task automatic run_line(input int len, input int pulse, input bit vs,
                            input int clr_at, input string req);
        int    mis = 0;
        string fname = "";
        int    fact = 0, fexp = 0;
        vsync_n   = vs;
        nvalid    = 0;
        first_col = -1;
        last_col  = -1;
        last_line = -1;
        for (int j = 0; j < len; j++) begin
            int hs_st, hs_sp, e_v, e_c, e_l;
            hsync_n = (j < pulse) ? 1'b0 : 1'b1;
            err_clr = (j == clr_at);
            @(posedge clk);
            if (j == clr_at)
                m_err = 0;
            else if (j == 2 && seen == 1 && !len_legal(last_len, m_mode))
                m_err = 1;
            if (j == 2) begin
                seen   = 1;
                m_pos  = 0;
                m_line = (m_line < 511) ? m_line + 1 : 511;
            end else if (m_pos < 2047) begin
                m_pos++;
            end
            if (j == pulse + 2) begin
                if (m_vs_prev == 1 && vs == 1'b0) begin
                    m_line = 0;
                    m_mode = samp_ind;
                end
                m_vs_prev = vs;
            end
            @(negedge clk);
            hs_st = (m_mode == 1) ? 205 : 84;
            hs_sp = (m_mode == 1) ? 960 : 320;
            e_v = (m_pos >= hs_st && m_pos < hs_st + hs_sp &&
                   m_line >= 20 && m_line < 254) ? 1 : 0;
            e_c = 0;
            e_l = 0;
            if (e_v == 1) begin
                e_c = hdir_asc ? (m_pos - hs_st) : (hs_sp - 1 - (m_pos - hs_st));
                e_l = vdir_asc ? (m_line - 20) : (233 - (m_line - 20));
            end
            if (mis == 0) begin
                if (int'(data_valid) != e_v) begin
                    fname = "data_valid"; fact = int'(data_valid); fexp = e_v;
                end else if (int'(col_addr) != e_c) begin
                    fname = "col_addr"; fact = int'(col_addr); fexp = e_c;
                end else if (int'(line_addr) != e_l) begin
                    fname = "line_addr"; fact = int'(line_addr); fexp = e_l;
                end else if (int'(line_len_err) != m_err) begin
                    fname = "line_len_err"; fact = int'(line_len_err); fexp = m_err;
                end
            end
            if (fname != "" && mis == 0) mis = 1;
            if (data_valid) begin
                nvalid++;
                if (first_col < 0) first_col = int'(col_addr);
                last_col  = int'(col_addr);
                last_line = int'(line_addr);
            end
        end
        last_len = len;
        err_clr  = 1'b0;
        check(mis == 0, req, {"per-cycle outputs, first bad ", fname}, fact, fexp);
    endtask

    task automatic t_reset();
        rst = 1'b1; hsync_n = 1'b1; vsync_n = 1'b1; samp_ind = 1'b1;
        hdir_asc = 1'b1; vdir_asc = 1'b1; err_clr = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(data_valid == 1'b0, "R1", "data_valid in reset", int'(data_valid), 0);
        check(col_addr == 10'd0 && line_addr == 8'd0, "R1", "addresses in reset",
              int'(col_addr) + int'(line_addr), 0);
        check(line_len_err == 1'b0, "R1", "line_len_err in reset", int'(line_len_err), 0);
        rst = 1'b0;
        @(negedge clk);
        check(data_valid == 1'b0 && line_len_err == 1'b0, "R1", "outputs after release",
              int'(data_valid) + int'(line_len_err), 0);
    endtask

    task automatic t_ind_frame();
        hdir_asc = 1'b1; vdir_asc = 1'b1;
        run_line(1200, 8, 1'b0, -1, "R2");
        for (int k = 1; k < 20; k++) run_line(1200, 8, 1'b1, -1, "R8");
        run_line(1200, 8, 1'b1, -1, "R3");
        check(nvalid == 960, "R3", "valid cycles on line 20", nvalid, 960);
        check(first_col == 0, "R3", "first column", first_col, 0);
        check(last_col == 959, "R6", "last ascending column", last_col, 959);
        check(last_line == 0, "R5", "first visible line address", last_line, 0);
    endtask

    task automatic t_len_ind();
        run_line(1169, 8, 1'b1, -1, "R9");
        run_line(1200, 8, 1'b1, -1, "R9");
        check(line_len_err == 1'b1, "R9", "flag after 1169-clock line", int'(line_len_err), 1);
        run_line(1200, 8, 1'b1, -1, "R9");
        check(line_len_err == 1'b1, "R9", "flag sticky", int'(line_len_err), 1);
        run_line(1230, 8, 1'b1, 100, "R10");
        check(line_len_err == 1'b0, "R10", "flag after clear", int'(line_len_err), 0);
        run_line(1170, 8, 1'b1, -1, "R9");
        run_line(1231, 8, 1'b1, -1, "R9");
        check(line_len_err == 1'b0, "R9", "1230 and 1170 legal", int'(line_len_err), 0);
        run_line(1200, 8, 1'b1, 2, "R10");
        check(line_len_err == 1'b0, "R10", "clear wins over same-edge set",
              int'(line_len_err), 0);
    endtask

    task automatic t_mode_defer();
        samp_ind = 1'b0;
        run_line(1200, 8, 1'b1, -1, "R11");
        check(nvalid == 960, "R11", "old window kept before frame start", nvalid, 960);
    endtask

    task automatic t_sim_frame();
        run_line(435, 8, 1'b0, -1, "R11");
        for (int k = 1; k < 256; k++) begin
            run_line(435, 8, 1'b1, -1, "R4");
            if (k == 20) begin
                check(nvalid == 320, "R4", "valid cycles per line", nvalid, 320);
                check(first_col == 0, "R4", "first pixel column", first_col, 0);
                check(last_col == 319, "R4", "last pixel column", last_col, 319);
            end
            if (k == 253)
                check(last_line == 233, "R5", "last visible line address", last_line, 233);
            if (k == 254)
                check(nvalid == 0, "R5", "line 254 blank", nvalid, 0);
        end
        check(line_len_err == 1'b0, "R9", "435-clock lines legal", int'(line_len_err), 0);
    endtask

    task automatic t_reverse();
        hdir_asc = 1'b0; vdir_asc = 1'b0;
        run_line(435, 8, 1'b0, -1, "R7");
        for (int k = 1; k < 20; k++) run_line(435, 8, 1'b1, -1, "R7");
        run_line(435, 8, 1'b1, -1, "R6");
        check(first_col == 319, "R6", "mirrored first column", first_col, 319);
        check(last_col == 0, "R6", "mirrored last column", last_col, 0);
        check(last_line == 233, "R7", "mirrored first line", last_line, 233);
        hdir_asc = 1'b1; vdir_asc = 1'b1;
    endtask

    task automatic t_len_sim();
        run_line(404, 8, 1'b1, -1, "R9");
        run_line(435, 8, 1'b1, -1, "R9");
        check(line_len_err == 1'b1, "R9", "flag after 404-clock line", int'(line_len_err), 1);
        run_line(405, 8, 1'b1, 50, "R10");
        run_line(465, 8, 1'b1, -1, "R9");
        check(line_len_err == 1'b0, "R9", "405 legal", int'(line_len_err), 0);
        run_line(466, 8, 1'b1, -1, "R9");
        check(line_len_err == 1'b0, "R9", "465 legal", int'(line_len_err), 0);
        run_line(435, 8, 1'b1, -1, "R9");
        check(line_len_err == 1'b1, "R9", "flag after 466-clock line", int'(line_len_err), 1);
    endtask

    initial begin
        t_reset();
        t_ind_frame();
        t_len_ind();
        t_mode_defer();
        t_sim_frame();
        t_reverse();
        t_len_sim();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule